// File: doc/BRIEF.md
# LPDDR2 Mode-Register Bring-Up Sequencer

This block walks one or two LPDDR2 chip selects through their mode-register setup after power-on. It talks to the memory controller through a small command port. Each command carries a valid/ready handshake, a write/read flag, a chip-select bit, an MR address, write data and a returned read byte. A single `start` pulse launches the whole sequence, and `done` pulses when it is complete.

For each chip select the sequencer runs the same steps in order:

1. Poll MR0 until the device reports that its auto-initialisation has finished.
2. Issue ZQ-init calibration through MR10.
3. Stay silent for the calibration time. The length of this wait is derived from the clock frequency parameter.
4. Program MR1 (burst setup) and MR16 (full-array refresh).
5. Write the read-latency code into MR2, with a refresh-enable flag raised on that same command.

The second chip select is brought up only when the second-bank input is set at start. The read latency is also taken at start.

Top module: `mrseq_top`

## Requirements
- R1: While reset is asserted and while idle, `cmd_valid`, `done` and `busy` are low, and no command is issued.
- R2: After `start`, the first commands are reads (`cmd_write`=0) of MR address 0 on chip select 0. The read is repeated for as long as bit 0 of the returned `cmd_rdata` is 1. The other bits of `cmd_rdata` have no effect.
- R3: Once a poll returns bit 0 = 0, the next command is a write to MR address 10 with data 0xFF.
- R4: The next command after the MR10 write appears exactly WAIT_CYCLES clock cycles after the MR10 handshake edge. WAIT_CYCLES = ceil(CLK_MHZ*ZQ_WAIT_NS/1000), which is 250 by default.
- R5: The next command writes MR address 1 with 0x23. In that byte, bits 2:0 = 3 select a burst of 8, bit 3 = 0 selects sequential, bit 4 = 0 selects wrap, and bits 7:5 = 1 select write-recovery code 3.
- R6: The next command writes MR address 16 with 0x00, which selects refresh of the full array.
- R7: The next command writes MR address 2 with data equal to the read latency minus 2, and `cmd_refen`=1. `cmd_refen` is 0 on every other command.
- R8: When `dual_rank` is 1 at the `start` cycle, the whole sequence repeats with `cmd_cs`=1 after chip select 0 finishes. Otherwise no command ever carries `cmd_cs`=1. Later changes of `dual_rank` have no effect.
- R9: A command that is not accepted stays valid with its address, data, chip select and flags unchanged until `cmd_ready` is seen.
- R10: `done` is high for exactly one cycle, the cycle after the final MR2 write is accepted. A `start` while busy is ignored and issues no extra command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (released synchronously) |
| start | input | 1 | Begin the bring-up sequence (taken only when idle) |
| dual_rank | input | 1 | Also bring up chip select 1 (sampled at start) |
| read_lat | input | RL_W | Read latency in clocks (sampled at start) |
| cmd_valid | output | 1 | Command presented |
| cmd_ready | input | 1 | Command accepted this cycle |
| cmd_write | output | 1 | 1 = mode-register write, 0 = read |
| cmd_cs | output | 1 | Target chip select |
| cmd_addr | output | ADDR_W | Mode-register address |
| cmd_wdata | output | DATA_W | Write data (0 on reads) |
| cmd_refen | output | 1 | Refresh enable, raised with the final write |
| cmd_rdata | input | DATA_W | Read data, sampled at a read handshake |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Commands are combinational from the state register. Each expected command is therefore compared on the falling edge that precedes the handshake edge, and the read data for a poll is driven in that same half cycle.

The calibration gap is measured in rising edges. The count runs from the edge that accepts MR10 to the first cycle in which the MR1 command is visible, and it must equal WAIT_CYCLES.

`done` rises one edge after the last MR2 handshake. The bench counts its high cycles on falling edges a few cycles later, expecting exactly one, and confirms the queue of expected commands is empty with `cmd_valid` low.

// File: rtl/mrseq_pkg.sv
package mrseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL,
    ST_ZQ,
    ST_WAIT,
    ST_BURST,
    ST_REFR,
    ST_LAT
  } seq_state_t;

  // mode-register addresses
  localparam logic [7:0] MRA_STATUS = 8'd0;
  localparam logic [7:0] MRA_BURST  = 8'd1;
  localparam logic [7:0] MRA_LAT    = 8'd2;
  localparam logic [7:0] MRA_ZQ     = 8'd10;
  localparam logic [7:0] MRA_REFR   = 8'd16;

  // write codes
  localparam logic [7:0] ZQ_INIT_CODE = 8'hFF;
  localparam logic [7:0] BURST_CODE   = 8'h23; // BL8, sequential, wrap, nWR code 3
  localparam logic [7:0] REFR_FULL    = 8'h00;

  // status bit: auto-initialisation still running
  localparam int AUTOINIT_BIT = 0;

endpackage

// File: rtl/mrseq_timer.sv
module mrseq_timer #(
  parameter int CYCLES = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = CW'(CYCLES);
    else      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == CW'(1));
endmodule

// File: rtl/mrseq_fsm.sv
module mrseq_fsm
  import mrseq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int RL_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dual_rank,
  input  logic [RL_W-1:0]   read_lat,
  input  logic              cmd_ready,
  input  logic [DATA_W-1:0] cmd_rdata,
  input  logic              wait_done,
  output logic              wait_load,
  output logic              cmd_valid,
  output logic              cmd_write,
  output logic              cmd_cs,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_refen,
  output logic              busy,
  output logic              done
);
  seq_state_t      state_q, state_d;
  logic            cs_q, cs_d;
  logic            dual_q;
  logic [RL_W-1:0] rl_q;
  logic            done_q, done_d;
  logic            cfg_en;
  logic            accept;

  assign accept = cmd_valid && cmd_ready;

  // next-state logic
  always_comb begin
    state_d   = state_q;
    cs_d      = cs_q;
    done_d    = 1'b0;
    wait_load = 1'b0;
    cfg_en    = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_POLL;
        cs_d    = 1'b0;
        cfg_en  = 1'b1;
      end
      ST_POLL: if (accept && !cmd_rdata[AUTOINIT_BIT]) state_d = ST_ZQ;
      ST_ZQ: if (accept) begin
        state_d   = ST_WAIT;
        wait_load = 1'b1;
      end
      ST_WAIT:  if (wait_done) state_d = ST_BURST;
      ST_BURST: if (accept) state_d = ST_REFR;
      ST_REFR:  if (accept) state_d = ST_LAT;
      ST_LAT: if (accept) begin
        if (!cs_q && dual_q) begin
          cs_d    = 1'b1;
          state_d = ST_POLL;
        end else begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // command decode
  always_comb begin
    cmd_valid = 1'b1;
    cmd_write = 1'b1;
    cmd_refen = 1'b0;
    cmd_addr  = '0;
    cmd_wdata = '0;
    case (state_q)
      ST_POLL: begin
        cmd_write = 1'b0;
        cmd_addr  = ADDR_W'(MRA_STATUS);
      end
      ST_ZQ: begin
        cmd_addr  = ADDR_W'(MRA_ZQ);
        cmd_wdata = DATA_W'(ZQ_INIT_CODE);
      end
      ST_BURST: begin
        cmd_addr  = ADDR_W'(MRA_BURST);
        cmd_wdata = DATA_W'(BURST_CODE);
      end
      ST_REFR: begin
        cmd_addr  = ADDR_W'(MRA_REFR);
        cmd_wdata = DATA_W'(REFR_FULL);
      end
      ST_LAT: begin
        cmd_addr  = ADDR_W'(MRA_LAT);
        cmd_wdata = {{(DATA_W-RL_W){1'b0}}, rl_q} - DATA_W'(2);
        cmd_refen = 1'b1;
      end
      default: begin
        cmd_valid = 1'b0;
        cmd_write = 1'b0;
      end
    endcase
  end

  assign cmd_cs = cs_q;
  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_q    <= cs_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dual_q <= 1'b0;
      rl_q   <= '0;
    end else if (cfg_en) begin
      dual_q <= dual_rank;
      rl_q   <= read_lat;
    end
  end
endmodule

// File: rtl/mrseq_top.sv
module mrseq_top #(
  parameter int CLK_MHZ    = 250,
  parameter int ZQ_WAIT_NS = 1000,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int RL_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dual_rank,
  input  logic [RL_W-1:0]   read_lat,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_write,
  output logic              cmd_cs,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_refen,
  input  logic [DATA_W-1:0] cmd_rdata,
  output logic              busy,
  output logic              done
);
  localparam int WAIT_CYCLES = (CLK_MHZ * ZQ_WAIT_NS + 999) / 1000;

  logic wait_load;
  logic wait_done;

  mrseq_timer #(.CYCLES(WAIT_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (wait_load),
    .expired (wait_done)
  );

  mrseq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RL_W(RL_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dual_rank (dual_rank),
    .read_lat  (read_lat),
    .cmd_ready (cmd_ready),
    .cmd_rdata (cmd_rdata),
    .wait_done (wait_done),
    .wait_load (wait_load),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_cs    (cmd_cs),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .cmd_refen (cmd_refen),
    .busy      (busy),
    .done      (done)
  );
endmodule

// File: rtl/mrseq_checker.sv
module mrseq_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_write,
  input logic              cmd_cs,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [DATA_W-1:0] cmd_wdata,
  input logic              cmd_refen,
  input logic              busy,
  input logic              done
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);

  assert_zq_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_write && cmd_addr == ADDR_W'(10)) |=> !cmd_valid);

  assert_refen_on_mr2_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_refen |-> (cmd_valid && cmd_write && cmd_addr == ADDR_W'(2)));

  assert_hold_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_cs)
                                   && $stable(cmd_wdata) && $stable(cmd_write)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_refen) |=> (done || cmd_valid));
endmodule

bind mrseq_top mrseq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_write (cmd_write),
  .cmd_cs    (cmd_cs),
  .cmd_addr  (cmd_addr),
  .cmd_wdata (cmd_wdata),
  .cmd_refen (cmd_refen),
  .busy      (busy),
  .done      (done)
);

// File: tb/mrseq_top_tb.sv
`timescale 1ns/1ps
module mrseq_top_tb;
  localparam int W = 250;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic       dual_rank;
  logic [3:0] read_lat;
  logic       cmd_valid;
  logic       cmd_ready;
  logic       cmd_write;
  logic       cmd_cs;
  logic [7:0] cmd_addr;
  logic [7:0] cmd_wdata;
  logic       cmd_refen;
  logic [7:0] cmd_rdata;
  logic       busy;
  logic       done;

  typedef struct packed {
    logic       cs;
    logic       wr;
    logic       refen;
    logic [7:0] addr;
    logic [7:0] data;
  } item_t;

  item_t exp_q[$];
  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  int    polls_left[2];
  bit    stall_mode = 0;
  int    stall_ph = 0;
  int    mr10_acc_cyc = 0;
  bit    gap_pending = 0;
  item_t held;
  bit    held_v = 0;
  int    done_cnt = 0;

  mrseq_top u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dual_rank(dual_rank),
    .read_lat(read_lat), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_cs(cmd_cs), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_refen(cmd_refen), .cmd_rdata(cmd_rdata),
    .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic string req_of(input logic [7:0] a);
    case (a)
      8'd0:    return "R2";
      8'd10:   return "R3";
      8'd1:    return "R5";
      8'd16:   return "R6";
      default: return "R7";
    endcase
  endfunction

  // monitor / scoreboard and port responder
  always @(negedge clk) begin
    item_t cur;
    bit rdy;
    cur = {cmd_cs, cmd_write, cmd_refen, cmd_addr, cmd_wdata};
    if (rst_n) begin
      if (done) done_cnt++;
      if (held_v) chk(cmd_valid && cur == held, "R9", "held command changed", cur, held);
      held_v = 0;
      if (gap_pending && cmd_valid) begin
        chk(cyc - mr10_acc_cyc == W, "R4", "calibration gap", cyc - mr10_acc_cyc, W);
        gap_pending = 0;
      end
      stall_ph++;
      rdy = !stall_mode || (stall_ph % 3 != 0);
      if (cmd_valid && rdy) begin
        if (exp_q.size() == 0) begin
          chk(0, "R10", "unexpected command", cur, 0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk(cur == e, e.cs ? "R8" : req_of(e.addr), "command", cur, e);
        end
        if (!cmd_write) begin
          if (polls_left[cmd_cs] > 0) begin
            cmd_rdata = 8'h01;
            polls_left[cmd_cs]--;
          end else begin
            cmd_rdata = 8'hFE;  // only bit 0 matters
          end
        end
        if (cmd_write && cmd_addr == 8'd10) begin
          mr10_acc_cyc = cyc + 1;
          gap_pending = 1;
        end
      end else if (cmd_valid) begin
        held = cur;
        held_v = 1;
      end
      cmd_ready = rdy;
    end else begin
      cmd_ready = 1'b0;
    end
  end

  task automatic push_cs(input bit cs, input int polls, input int rl);
    for (int i = 0; i <= polls; i++) exp_q.push_back({cs, 1'b0, 1'b0, 8'd0, 8'd0});
    exp_q.push_back({cs, 1'b1, 1'b0, 8'd10, 8'hFF});
    exp_q.push_back({cs, 1'b1, 1'b0, 8'd1,  8'h23});
    exp_q.push_back({cs, 1'b1, 1'b0, 8'd16, 8'h00});
    exp_q.push_back({cs, 1'b1, 1'b1, 8'd2,  8'(rl - 2)});
  endtask

  task automatic run_seq(input bit dual, input int rl, input int p0, input int p1,
                         input bit stall, input bit flip_dual);
    int t;
    stall_mode = stall;
    polls_left[0] = p0;
    polls_left[1] = p1;
    push_cs(1'b0, p0, rl);
    if (dual) push_cs(1'b1, p1, rl);
    done_cnt = 0;
    dual_rank = dual;
    read_lat = 4'(rl);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (flip_dual) begin
      dual_rank = ~dual;
      read_lat = 4'(rl + 1);
    end
    repeat (20) @(negedge clk);
    start = 1'b1;                       // R10: ignored while busy
    @(negedge clk) start = 1'b0;
    t = 0;
    while (done_cnt == 0 && t < 5000) begin
      @(posedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, "R10", "done high cycles", done_cnt, 1);
    chk(exp_q.size() == 0, "R8", "commands left unissued", exp_q.size(), 0);
    chk(!cmd_valid && !busy, "R10", "idle after done", {cmd_valid, busy}, 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    dual_rank = 1'b0;
    read_lat = 4'd6;
    cmd_rdata = 8'h00;
    cmd_ready = 1'b0;
    repeat (2) @(negedge clk);
    start = 1'b1;
    repeat (3) @(negedge clk);
    chk(!cmd_valid && !done && !busy, "R1", "outputs in reset", {cmd_valid, done, busy}, 0);
    start = 1'b0;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!cmd_valid && !done && !busy, "R1", "idle after reset", {cmd_valid, done, busy}, 0);

    run_seq(1'b0, 6, 2, 0, 1'b1, 1'b0);   // single rank, stalls, two busy polls
    run_seq(1'b1, 8, 0, 3, 1'b0, 1'b0);   // dual rank, no stalls
    run_seq(1'b0, 3, 1, 2, 1'b1, 1'b1);   // dual_rank/read_lat change after start ignored
    run_seq(1'b1, 5, 4, 1, 1'b1, 1'b1);   // dual rank with stalls, inputs flip after start

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule